// File: doc/BRIEF.md
# Gatable Multivibrator and One-Shot Timer

A fully synchronous timer that stands in for a resistor-capacitor multivibrator. Two programmable cycle counts set the timing. `shot_len` sets the one-shot width. `half_len` sets each half of the free-running square wave. A count of zero acts as one cycle.

The block has two modes. In free-running mode, a gate input lets the main output toggle as a square wave. The gate can be an active-high or an active-low enable. In one-shot mode, a trigger edge produces a single pulse of fixed width. The trigger can be a rising edge on one input or a falling edge on the other. A retrigger level can stretch that pulse. A master reset clears the output at any time and wins over any trigger in the same cycle. An external countdown chain can use the gate input, because the first high half after enabling lasts one one-shot width.

The controller is one state machine with these states:

- `ST_IDLE`: output low.
- `ST_SHOT`: one-shot pulse.
- `ST_FIRST`: first high half after gating.
- `ST_HIGH` and `ST_LOW`: the free-running halves.

Its transitions are:

- idle→first when the gate is enabled.
- idle→shot on a trigger.
- shot→shot (count reload) on a trigger while retrigger is high.
- shot→idle when the count runs out.
- first→low when the count runs out.
- low→high and high→low when each half-count runs out.
- Any run state→idle when the gate is removed.
- Any state→idle on master reset.

Top module: `multivib_timer`

## Requirements
- R1: While `rst_n` is low, `pulse_q` is 0, `pulse_qn` is 1 and `osc_out` is 0.
- R2: Free-running operation is enabled when `gate_hi` is 1 or `gate_lo_n` is 0.
  - `pulse_q` rises 3 clock cycles after the enabling input changes, counting two synchronizer flops and the state register.
  - When neither gate condition holds, `pulse_q` returns low within 3 cycles and stays low.
- R3: Gated timing:
  - The first high half after enabling lasts `shot_len` cycles.
  - After that, `pulse_q` alternates low and high, each half lasting `half_len` cycles.
- R4: `pulse_qn` is always the exact inverse of `pulse_q`.
- R5: `osc_out` runs at twice the output rate:
  - In each free-running half it is high for the first ceil(`half_len`/2) cycles and low for the rest.
  - This gives two `osc_out` rising edges per `pulse_q` period.
  - It is 0 in idle, in a one-shot and in the first gated half.
- R6: Rising-edge trigger:
  - A rising edge on `trig_up` while `trig_dn` is low starts a one-shot pulse of `shot_len` cycles.
  - The pulse rises 3 cycles after the edge is driven.
  - A rising `trig_up` edge while `trig_dn` is high starts nothing.
- R7: A falling edge on `trig_dn` while `trig_up` is high starts the same one-shot pulse, with the same 3-cycle latency.
- R8: The one-shot width does not depend on how long the trigger is held. A new trigger edge during a pulse, with `retrig` low, has no effect.
- R9: A trigger edge during a pulse while `retrig` is high reloads the count. The pulse then ends `shot_len` cycles after the state change caused by the last such edge.
- R10: Master reset:
  - `mreset` high forces `pulse_q` and `osc_out` low on the next clock edge.
  - No pulse starts while `mreset` is high, even if a trigger arrives in the same cycle.
- R11: A `shot_len` or `half_len` of 0 is treated as a count of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| shot_len | input | CNT_W | One-shot width and first gated half, in cycles |
| half_len | input | CNT_W | Free-running half-period, in cycles |
| gate_hi | input | 1 | Active-high gate enable |
| gate_lo_n | input | 1 | Active-low gate enable |
| trig_up | input | 1 | Rising-edge trigger |
| trig_dn | input | 1 | Falling-edge trigger |
| retrig | input | 1 | Retrigger enable level |
| mreset | input | 1 | Master reset, active high, takes priority |
| pulse_q | output | 1 | Main output |
| pulse_qn | output | 1 | Complemented main output |
| osc_out | output | 1 | Double-rate oscillator output |

## Verification
The bench checks each trigger with exact cycle counts:

- A trigger held for many cycles must still give a `shot_len`-wide pulse. A design that gated the pulse with the trigger level would give the wrong width.
- A second edge with `retrig` low must leave the pulse at 6 cycles. A retriggering bug would stretch it to 9.
- Three closely spaced edges with `retrig` high must merge into one 14-cycle pulse. A design that ignored the retrigger would give 6 cycles.

Gated runs check the following:

- The long first half must last `shot_len` cycles. A design that used `half_len` here would break countdown chaining.
- The two-to-one rising-edge ratio of `osc_out` must hold.
- Zero counts must produce one-cycle halves and must not stall or wrap.

A trigger applied while `mreset` is held must produce no pulse. A design with the wrong priority would emit one.

// File: rtl/mv_pkg.sv
package mv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHOT,
        ST_FIRST,
        ST_HIGH,
        ST_LOW
    } mv_state_e;
endpackage

// File: rtl/mv_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
module mv_sync #(
    parameter int         N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level
);
    logic [N-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta  <= RST_VAL;
            level <= RST_VAL;
        end else begin
            meta  <= din;
            level <= meta;
        end
    end
endmodule

// File: rtl/mv_delay.sv
// One-cycle history register used for edge detection.
module mv_delay #(
    parameter int           N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= RST_VAL;
        else        dout <= din;
    end
endmodule

// File: rtl/mv_len.sv
// Clamps a programmed cycle count so that zero behaves as one.
module mv_len #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb eff = (raw == '0) ? ONE : raw;
endmodule

// File: rtl/mv_fsm.sv
// Timing state machine with one shared down-counter.
module mv_fsm
    import mv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mreset,
    input  logic         run_en,
    input  logic         fire,
    input  logic         retrig_lvl,
    input  logic [W-1:0] shot_cycles,
    input  logic [W-1:0] half_cycles,
    output logic         pulse_q,
    output logic         osc_out
);
    localparam logic [W-1:0] ONE = W'(1);

    mv_state_e    state, state_nx;
    logic [W-1:0] cnt, load_val;
    logic         reload;
    logic         cnt_done;

    assign cnt_done = (cnt == '0);

    // next-state logic
    always_comb begin
        state_nx = state;
        reload   = 1'b0;
        if (mreset) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run_en)    state_nx = ST_FIRST;
                    else if (fire) state_nx = ST_SHOT;
                end
                ST_SHOT: begin
                    if (fire && retrig_lvl) reload   = 1'b1;
                    else if (cnt_done)      state_nx = ST_IDLE;
                end
                ST_FIRST: begin
                    if (!run_en)       state_nx = ST_IDLE;
                    else if (cnt_done) state_nx = ST_LOW;
                end
                ST_HIGH: begin
                    if (!run_en)       state_nx = ST_IDLE;
                    else if (cnt_done) state_nx = ST_LOW;
                end
                ST_LOW: begin
                    if (!run_en)       state_nx = ST_IDLE;
                    else if (cnt_done) state_nx = ST_HIGH;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // length of the phase being entered
    always_comb begin
        unique case (state_nx)
            ST_SHOT, ST_FIRST: load_val = shot_cycles - ONE;
            ST_HIGH, ST_LOW:   load_val = half_cycles - ONE;
            default:           load_val = '0;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state || reload) cnt <= load_val;
            else if (!cnt_done)               cnt <= cnt - ONE;
        end
    end

    // outputs
    always_comb begin
        pulse_q = 1'b0;
        osc_out = 1'b0;
        unique case (state)
            ST_SHOT, ST_FIRST: pulse_q = 1'b1;
            ST_HIGH: begin
                pulse_q = 1'b1;
                osc_out = (cnt >= (half_cycles >> 1));
            end
            ST_LOW:  osc_out = (cnt >= (half_cycles >> 1));
            default: pulse_q = 1'b0;
        endcase
    end
endmodule

// File: rtl/multivib_timer.sv
module multivib_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] shot_len,
    input  logic [CNT_W-1:0] half_len,
    input  logic             gate_hi,
    input  logic             gate_lo_n,
    input  logic             trig_up,
    input  logic             trig_dn,
    input  logic             retrig,
    input  logic             mreset,
    output logic             pulse_q,
    output logic             pulse_qn,
    output logic             osc_out
);
    // bundle order: {gate_lo_n, gate_hi, retrig, trig_dn, trig_up}
    localparam int         NIN     = 5;
    localparam logic [NIN-1:0] IN_IDLE = 5'b10000;

    logic [NIN-1:0]   lvl;
    logic [1:0]       trg_prev;
    logic [CNT_W-1:0] shot_eff, half_eff;
    logic             run_en, fire;

    mv_sync #(.N(NIN), .RST_VAL(IN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({gate_lo_n, gate_hi, retrig, trig_dn, trig_up}),
        .level (lvl)
    );

    mv_delay #(.N(2), .RST_VAL(2'b00)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lvl[1:0]),
        .dout  (trg_prev)
    );

    mv_len #(.W(CNT_W)) u_shot_len (.raw(shot_len), .eff(shot_eff));
    mv_len #(.W(CNT_W)) u_half_len (.raw(half_len), .eff(half_eff));

    assign run_en = lvl[3] | ~lvl[4];
    assign fire   = (lvl[0] & ~trg_prev[0] & ~lvl[1])
                  | (~lvl[1] & trg_prev[1] & lvl[0]);

    mv_fsm #(.W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreset      (mreset),
        .run_en      (run_en),
        .fire        (fire),
        .retrig_lvl  (lvl[2]),
        .shot_cycles (shot_eff),
        .half_cycles (half_eff),
        .pulse_q     (pulse_q),
        .osc_out     (osc_out)
    );

    assign pulse_qn = ~pulse_q;
endmodule

// File: rtl/mv_checker.sv
module mv_checker (
    input logic clk,
    input logic rst_n,
    input logic mreset,
    input logic pulse_q,
    input logic pulse_qn,
    input logic osc_out
);
    assert_complement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q != pulse_qn);

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> !pulse_q);

    assert_no_start_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> !$past(mreset));

    assert_osc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> !osc_out);
endmodule

bind multivib_timer mv_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mreset   (mreset),
    .pulse_q  (pulse_q),
    .pulse_qn (pulse_qn),
    .osc_out  (osc_out)
);

// File: tb/multivib_timer_test.sv
module multivib_timer_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] shot_len = W'(6);
    logic [W-1:0] half_len = W'(4);
    logic         gate_hi = 1'b0, gate_lo_n = 1'b1;
    logic         trig_up = 1'b0, trig_dn = 1'b0, retrig = 1'b0, mreset = 1'b0;
    logic         pulse_q, pulse_qn, osc_out;

    int checks = 0;
    int fails = 0;
    int inv_err = 0;

    always #10 clk = ~clk;

    multivib_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .shot_len(shot_len), .half_len(half_len),
        .gate_hi(gate_hi), .gate_lo_n(gate_lo_n), .trig_up(trig_up),
        .trig_dn(trig_dn), .retrig(retrig), .mreset(mreset),
        .pulse_q(pulse_q), .pulse_qn(pulse_qn), .osc_out(osc_out)
    );

    always @(negedge clk) if (rst_n && pulse_qn !== ~pulse_q) inv_err++;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_high(output int n);
        n = 0;
        do begin tick(); n++; end while (!pulse_q && n < 50);
    endtask

    task automatic run_len(input logic v, output int n);
        n = 1;
        tick();
        while (pulse_q === v && n < 200) begin n++; tick(); end
    endtask

    task automatic count_high(input int cyc, output int n);
        n = 0;
        repeat (cyc) begin tick(); if (pulse_q) n++; end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check_eq("R1 pulse_q", int'(pulse_q), 0);
        check_eq("R1 pulse_qn", int'(pulse_qn), 1);
        check_eq("R1 osc_out", int'(osc_out), 0);
        rst_n = 1'b1;
        repeat (3) tick();
    endtask

    task automatic t_rise_trigger();
        int n;
        trig_up = 1'b1;
        wait_high(n);   check_eq("R6 latency", n, 3);
        run_len(1, n);  check_eq("R8 width with long trigger", n, 6);
        repeat (10) tick();
        trig_up = 1'b0;
        repeat (6) tick();
        trig_up = 1'b1; tick(); trig_up = 1'b0;
        wait_high(n);   check_eq("R6 latency short trigger", n, 2);
        run_len(1, n);  check_eq("R8 width with short trigger", n, 6);
        repeat (4) tick();
    endtask

    task automatic t_fall_trigger();
        int n;
        trig_dn = 1'b1;
        repeat (4) tick();
        trig_up = 1'b1;
        count_high(12, n); check_eq("R6 blocked when trig_dn high", n, 0);
        trig_dn = 1'b0;
        wait_high(n);   check_eq("R7 latency", n, 3);
        run_len(1, n);  check_eq("R7 width", n, 6);
        trig_up = 1'b0;
        repeat (8) tick();
    endtask

    task automatic t_no_retrig();
        int n = 0;
        for (int i = 0; i < 25; i++) begin
            if (i == 0 || i == 3) trig_up = 1'b1;
            if (i == 1 || i == 4) trig_up = 1'b0;
            tick();
            if (pulse_q) n++;
        end
        check_eq("R8 second edge ignored", n, 6);
    endtask

    task automatic t_retrig();
        int n = 0;
        int rises = 0;
        logic prev = 1'b0;
        retrig = 1'b1;
        repeat (4) tick();
        for (int i = 0; i < 30; i++) begin
            if (i == 0 || i == 4 || i == 8) trig_up = 1'b1;
            if (i == 1 || i == 5 || i == 9) trig_up = 1'b0;
            tick();
            if (pulse_q) n++;
            if (pulse_q && !prev) rises++;
            prev = pulse_q;
        end
        check_eq("R9 stretched width", n, 14);
        check_eq("R9 single pulse", rises, 1);
        retrig = 1'b0;
        repeat (4) tick();
    endtask

    task automatic t_mreset();
        int n;
        trig_up = 1'b1; tick(); trig_up = 1'b0;
        wait_high(n);
        tick();
        mreset = 1'b1;
        tick();
        check_eq("R10 pulse cut", int'(pulse_q), 0);
        check_eq("R10 osc low", int'(osc_out), 0);
        repeat (8) tick();
        trig_up = 1'b1; tick(); trig_up = 1'b0;
        count_high(10, n); check_eq("R10 trigger blocked", n, 0);
        mreset = 1'b0;
        count_high(10, n); check_eq("R10 no late pulse", n, 0);
    endtask

    task automatic t_gate_true();
        int n;
        int orise = 0;
        int mrise = 0;
        logic op = 1'b0;
        logic mp = 1'b1;
        gate_hi = 1'b1;
        wait_high(n);  check_eq("R2 gate latency", n, 3);
        run_len(1, n); check_eq("R3 first half", n, 6);
        for (int i = 0; i < 16; i++) begin
            if (osc_out && !op) orise++;
            if (pulse_q && !mp) mrise++;
            op = osc_out;
            mp = pulse_q;
            tick();
        end
        check_eq("R5 main rises", mrise, 2);
        check_eq("R5 osc rises", orise, 4);
        gate_hi = 1'b0;
        repeat (4) tick();
        count_high(10, n); check_eq("R2 stopped", n, 0);
        check_eq("R5 osc idle", int'(osc_out), 0);
    endtask

    task automatic t_gate_comp();
        int n;
        gate_lo_n = 1'b0;
        wait_high(n);  check_eq("R2 complement gate latency", n, 3);
        run_len(1, n); check_eq("R3 first half complement", n, 6);
        run_len(0, n); check_eq("R3 low half", n, 4);
        run_len(1, n); check_eq("R3 high half", n, 4);
        run_len(0, n); check_eq("R3 second low half", n, 4);
        gate_lo_n = 1'b1;
        repeat (4) tick();
        count_high(8, n); check_eq("R2 complement stopped", n, 0);
    endtask

    task automatic t_zero_len();
        int n;
        shot_len = '0;
        half_len = '0;
        tick();
        trig_up = 1'b1; tick(); trig_up = 1'b0;
        wait_high(n);
        run_len(1, n); check_eq("R11 zero shot width", n, 1);
        repeat (6) tick();
        gate_hi = 1'b1;
        wait_high(n);  check_eq("R11 gate latency", n, 3);
        run_len(1, n); check_eq("R11 first half", n, 1);
        run_len(0, n); check_eq("R11 low half", n, 1);
        run_len(1, n); check_eq("R11 high half", n, 1);
        gate_hi = 1'b0;
        repeat (6) tick();
        shot_len = W'(6);
        half_len = W'(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_rise_trigger();
        t_fall_trigger();
        t_no_retrig();
        t_retrig();
        t_mreset();
        t_gate_true();
        t_gate_comp();
        t_zero_len();
        check_eq("R4 complement mismatches", inv_err, 0);
        summary();
        $finish;
    end
endmodule